// File: doc/BRIEF.md
# CEC Byte Receiver with Short-Cycle Signalling

This block listens to a Consumer Electronics Control line and rebuilds the frame one byte at a time. Every bit starts with a falling edge. The time the line stays low sets the bit value, and the time to the next falling edge is checked against a window. Each byte carries eight data bits, most significant first, then an end-of-message bit, then the acknowledge slot. The block reports what it sees through a set of sticky status flags and a one-cycle interrupt pulse. Software clears the flags by writing ones.

A bit cycle that ends too early counts as a short-cycle error. The receiver answers it by pulling the line low for a fixed time, about 3.6 ms. A bit cycle that runs too long counts as a long-cycle error. When the defer input is high, long-cycle errors do not raise an interrupt at once and do not stop reception. They are held back and reported together with the next byte result or with a timeout. Dropping the enable input abandons the frame at once, discards the partial byte and ends any low pulse the block is driving.

All timing is counted in ticks of about 0.05 ms. A prescaler parameter derives the tick from the system clock.

Top module: `cec_frame_rx`

## Requirements
- R1: After reset the status flags are 0, the received byte is 0, the interrupt is low and the line is not pulled.
- R2: A bit whose low phase is longer than BIT0_TICKS reads 0, otherwise 1. Data bits are shifted in most significant first. At the end of the acknowledge slot's low phase the byte appears on rx_data, flag bit 0 (byte received) is set and exactly one interrupt pulse is given, three clock cycles after the rising edge reaches the input.
- R3: A byte whose end-of-message bit is 1 also sets flag bit 1 (frame complete) and ends the frame. A byte with that bit at 0 leaves flag bit 1 clear and reception goes on. Each byte gives its own interrupt.
- R4: A falling edge less than MIN_CYCLE_TICKS after the previous one sets flag bit 3 (short cycle) and gives an interrupt at once, whatever the defer setting. The block then pulls the line low for ERR_TICKS ticks and drops the partial byte, so rx_data is unchanged.
- R5: With defer low, a bit period longer than MAX_CYCLE_TICKS sets flag bit 2 (long cycle), gives an interrupt and abandons the byte.
- R6: With defer high, a long-cycle error gives no interrupt of its own and reception goes on. At the end of that byte, flag bit 2 is set in the same cycle as bit 0, with a single interrupt.
- R7: A short-cycle error that follows a held long-cycle error sets bits 3 and 2 together, with one interrupt.
- R8: If no falling edge comes within TIMEOUT_TICKS during a frame, flag bit 4 (timeout) is set together with any held error bits, one interrupt is given and the frame is closed.
- R9: Clearing rx_en in the middle of a byte abandons it with no flag and no interrupt. The next frame after re-enabling decodes from its first bit.
- R10: Clearing rx_en while the low pulse is driven releases the line in the next cycle.
- R11: Flags stay set until a one is written to their bit in flag_clr. A one clears only its own bit.
- R12: While rx_en is low, line activity sets no flag, changes no data and gives no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_en | input | 1 | Receive enable |
| defer_en | input | 1 | Hold long-cycle errors until the byte ends |
| cec_in | input | 1 | Sensed level of the CEC line |
| cec_pull | output | 1 | 1 pulls the line low (open-drain drive) |
| flag_clr | input | 5 | Write-one-to-clear pulse for the flags |
| rx_data | output | DATA_W | Last completed byte |
| flags | output | 5 | Sticky status: 0 byte, 1 frame complete, 2 long cycle, 3 short cycle, 4 timeout |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A line edge travels through two synchroniser stages and one edge-history stage, then one result register. So rx_data, flags, irq and the start of the low pulse all change three clock cycles after the bench drives the edge. The bench drives on falling clock edges and checks the byte-end case on the second and third following falling edges, expecting the old value and then the new one. Timeouts and the low-pulse length depend on the tick phase, so the bench waits well past the tick window before sampling and measures the pulse against a one-tick tolerance. Release after disable is checked on the very next falling edge.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;
   localparam int NFLAG = 5;

   localparam int F_BYTE = 0;
   localparam int F_EOM  = 1;
   localparam int F_LONG = 2;
   localparam int F_MINC = 3;
   localparam int F_TOUT = 4;

   localparam logic [NFLAG-1:0] M_BYTE = NFLAG'(1) << F_BYTE;
   localparam logic [NFLAG-1:0] M_EOM  = NFLAG'(1) << F_EOM;
   localparam logic [NFLAG-1:0] M_LONG = NFLAG'(1) << F_LONG;
   localparam logic [NFLAG-1:0] M_MINC = NFLAG'(1) << F_MINC;
   localparam logic [NFLAG-1:0] M_TOUT = NFLAG'(1) << F_TOUT;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_ERRP,
      ST_WAITH
   } rx_state_e;
endpackage

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
   parameter int CLK_PER_TICK = 2500
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;

   generate
      if (CLK_PER_TICK < 1) begin : g_bad
         $error("cec_tick_gen: CLK_PER_TICK must be at least 1");
      end
      if (CLK_PER_TICK == 1) begin : g_pass
         logic tick_q;
         always_ff @(posedge clk) begin
            tick_q <= !rst;
         end
         assign tick = tick_q;
      end else begin : g_div
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst)
               cnt_q <= '0;
            else if (cnt_q == CW'(CLK_PER_TICK - 1))
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign tick = (cnt_q == CW'(CLK_PER_TICK - 1));
      end
   endgenerate
endmodule

// File: rtl/cec_line_sync.sv
module cec_line_sync (
   input  logic clk,
   input  logic rst,
   input  logic line_in,
   output logic level,
   output logic fall,
   output logic rise
);
   logic [2:0] hist_q;

   always_ff @(posedge clk) begin
      if (rst)
         hist_q <= 3'b111;
      else
         hist_q <= {hist_q[1:0], line_in};
   end

   assign level = hist_q[1];
   assign fall  = hist_q[2] & ~hist_q[1];
   assign rise  = ~hist_q[2] & hist_q[1];
endmodule

// File: rtl/cec_err_pulse.sv
module cec_err_pulse #(
   parameter int ERR_TICKS = 72
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic start,
   input  logic stop,
   output logic pull
);
   localparam int EW = $clog2(ERR_TICKS + 1);

   logic          active_q;
   logic [EW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || stop) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end else if (active_q && tick) begin
         if (cnt_q == EW'(ERR_TICKS - 1))
            active_q <= 1'b0;
         else
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign pull = active_q;
endmodule

// File: rtl/cec_frame_rx.sv
module cec_frame_rx
   import cec_rx_pkg::*;
#(
   parameter int CLK_PER_TICK    = 2500,
   parameter int DATA_W          = 8,
   parameter int BIT0_TICKS      = 24,
   parameter int MIN_CYCLE_TICKS = 41,
   parameter int MAX_CYCLE_TICKS = 55,
   parameter int TIMEOUT_TICKS   = 80,
   parameter int ERR_TICKS       = 72
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rx_en,
   input  logic              defer_en,
   input  logic              cec_in,
   output logic              cec_pull,
   input  logic [NFLAG-1:0]  flag_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic [NFLAG-1:0]  flags,
   output logic              irq
);
   localparam int TW      = $clog2(TIMEOUT_TICKS + 1) + 1;
   localparam int BW      = $clog2(DATA_W + 2);
   localparam int EOM_IDX = DATA_W;
   localparam int ACK_IDX = DATA_W + 1;

   generate
      if (!(BIT0_TICKS < MIN_CYCLE_TICKS && MIN_CYCLE_TICKS < MAX_CYCLE_TICKS &&
            MAX_CYCLE_TICKS < TIMEOUT_TICKS && ERR_TICKS > 1 && DATA_W >= 1))
      begin : g_bad_cfg
         $error("cec_frame_rx: timing parameters out of order");
      end
   endgenerate

   logic tick, level, fall, rise;

   cec_tick_gen #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
      .clk (clk),
      .rst (rst),
      .tick(tick)
   );

   cec_line_sync u_sync (
      .clk    (clk),
      .rst    (rst),
      .line_in(cec_in),
      .level  (level),
      .fall   (fall),
      .rise   (rise)
   );

   logic start_p;
   logic pull;

   cec_err_pulse #(.ERR_TICKS(ERR_TICKS)) u_pulse (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .start(start_p),
      .stop (!rx_en),
      .pull (pull)
   );

   // time since the last falling edge, in ticks, saturating
   logic [TW-1:0] tcnt_q;
   always_ff @(posedge clk) begin
      if (rst || fall)
         tcnt_q <= '0;
      else if (tick && tcnt_q != {TW{1'b1}})
         tcnt_q <= tcnt_q + 1'b1;
   end

   rx_state_e         st_q, st_n;
   logic [BW-1:0]     bitn_q, bitn_n;
   logic [DATA_W-1:0] sh_q, sh_n;
   logic              eom_q, eom_n;
   logic [NFLAG-1:0]  pend_q, pend_n;
   logic [DATA_W-1:0] data_q;
   logic [NFLAG-1:0]  flags_q;
   logic              irq_q;

   logic [NFLAG-1:0]  set_m;
   logic              fire, load;
   logic              bit_val, timed_out, too_short, too_long;

   assign bit_val   = (tcnt_q <= TW'(BIT0_TICKS));
   assign timed_out = (tcnt_q >= TW'(TIMEOUT_TICKS));
   assign too_short = (tcnt_q <  TW'(MIN_CYCLE_TICKS));
   assign too_long  = (tcnt_q >  TW'(MAX_CYCLE_TICKS));

   always_comb begin
      st_n    = st_q;
      bitn_n  = bitn_q;
      sh_n    = sh_q;
      eom_n   = eom_q;
      pend_n  = pend_q;
      set_m   = '0;
      fire    = 1'b0;
      load    = 1'b0;
      start_p = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (fall) begin
               st_n   = ST_LOW;
               bitn_n = '0;
               pend_n = '0;
            end
         end
         ST_LOW: begin
            if (timed_out) begin
               set_m  = pend_q | M_TOUT;
               fire   = 1'b1;
               pend_n = '0;
               st_n   = ST_WAITH;
            end else if (rise) begin
               if (bitn_q < BW'(EOM_IDX))
                  sh_n = {sh_q[DATA_W-2:0], bit_val};
               if (bitn_q == BW'(EOM_IDX))
                  eom_n = bit_val;
               if (bitn_q == BW'(ACK_IDX)) begin
                  load   = 1'b1;
                  fire   = 1'b1;
                  set_m  = pend_q | M_BYTE | (eom_q ? M_EOM : '0);
                  pend_n = '0;
                  bitn_n = '0;
                  st_n   = eom_q ? ST_IDLE : ST_HIGH;
               end else begin
                  bitn_n = bitn_q + 1'b1;
                  st_n   = ST_HIGH;
               end
            end
         end
         ST_HIGH: begin
            if (timed_out) begin
               set_m  = pend_q | M_TOUT;
               fire   = 1'b1;
               pend_n = '0;
               st_n   = ST_IDLE;
            end else if (fall) begin
               if (too_short) begin
                  set_m   = pend_q | M_MINC;
                  fire    = 1'b1;
                  start_p = 1'b1;
                  pend_n  = '0;
                  st_n    = ST_ERRP;
               end else if (too_long && defer_en) begin
                  pend_n = pend_q | M_LONG;
                  st_n   = ST_LOW;
               end else if (too_long) begin
                  set_m  = pend_q | M_LONG;
                  fire   = 1'b1;
                  pend_n = '0;
                  st_n   = ST_WAITH;
               end else begin
                  st_n = ST_LOW;
               end
            end
         end
         ST_ERRP: begin
            if (!pull)
               st_n = ST_WAITH;
         end
         ST_WAITH: begin
            if (level)
               st_n = ST_IDLE;
         end
         default: st_n = ST_IDLE;
      endcase

      if (!rx_en) begin
         st_n    = ST_IDLE;
         pend_n  = '0;
         set_m   = '0;
         fire    = 1'b0;
         load    = 1'b0;
         start_p = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_IDLE;
         bitn_q  <= '0;
         sh_q    <= '0;
         eom_q   <= 1'b0;
         pend_q  <= '0;
         data_q  <= '0;
         flags_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         st_q    <= st_n;
         bitn_q  <= bitn_n;
         sh_q    <= sh_n;
         eom_q   <= eom_n;
         pend_q  <= pend_n;
         if (load)
            data_q <= sh_q;
         flags_q <= (flags_q & ~flag_clr) | set_m;
         irq_q   <= fire;
      end
   end

   assign cec_pull = pull;
   assign rx_data  = data_q;
   assign flags    = flags_q;
   assign irq      = irq_q;
endmodule

// File: rtl/cec_frame_rx_chk.sv
module cec_frame_rx_chk #(
   parameter int CLK_PER_TICK = 2500,
   parameter int DATA_W       = 8,
   parameter int ERR_TICKS    = 72
) (
   input logic              clk,
   input logic              rst,
   input logic              rx_en,
   input logic              cec_pull,
   input logic [4:0]        flag_clr,
   input logic [DATA_W-1:0] rx_data,
   input logic [4:0]        flags,
   input logic              irq
);
   localparam int LIMIT = ERR_TICKS * CLK_PER_TICK;

   int plen;
   always_ff @(posedge clk) begin
      if (rst)
         plen <= 0;
      else
         plen <= cec_pull ? plen + 1 : 0;
   end

   a_r10_pull_release: assert property (@(posedge clk) disable iff (rst)
      !rx_en |=> !cec_pull);

   a_r12_pull_needs_en: assert property (@(posedge clk) disable iff (rst)
      cec_pull |-> $past(rx_en));

   a_r4_pull_length: assert property (@(posedge clk) disable iff (rst)
      cec_pull |-> (plen < LIMIT));

   a_r2_irq_single: assert property (@(posedge clk) disable iff (rst)
      irq |=> !irq);

   a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
      ((($past(flags) & ~$past(flag_clr)) & ~flags) == 5'd0));

   a_r7_flag_with_irq: assert property (@(posedge clk) disable iff (rst)
      ((flags & ~$past(flags)) != 5'd0) |-> irq);

   a_r3_data_with_irq: assert property (@(posedge clk) disable iff (rst)
      !$stable(rx_data) |-> irq);
endmodule

bind cec_frame_rx cec_frame_rx_chk #(
   .CLK_PER_TICK(CLK_PER_TICK),
   .DATA_W      (DATA_W),
   .ERR_TICKS   (ERR_TICKS)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .rx_en   (rx_en),
   .cec_pull(cec_pull),
   .flag_clr(flag_clr),
   .rx_data (rx_data),
   .flags   (flags),
   .irq     (irq)
);

// File: tb/cec_frame_rx_bench.sv
module cec_frame_rx_bench;
   localparam int PRE = 4;
   localparam int NOM = 48;
   localparam int LO1 = 12;
   localparam int LO0 = 30;
   localparam int ERR = 72;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rx_en = 1'b0;
   logic       defer_en = 1'b0;
   logic       drv = 1'b1;
   logic [4:0] flag_clr = 5'd0;
   logic       cec_pull, irq;
   logic [7:0] rx_data;
   logic [4:0] flags;
   logic       cec_line;

   int n_chk = 0;
   int n_fail = 0;
   int irq_cnt = 0;
   int irq_base = 0;

   always #10 clk = ~clk;

   assign cec_line = drv & ~cec_pull;

   cec_frame_rx #(.CLK_PER_TICK(PRE)) u_cec_frame_rx (
      .clk     (clk),
      .rst     (rst),
      .rx_en   (rx_en),
      .defer_en(defer_en),
      .cec_in  (cec_line),
      .cec_pull(cec_pull),
      .flag_clr(flag_clr),
      .rx_data (rx_data),
      .flags   (flags),
      .irq     (irq)
   );

   always @(posedge clk) if (!rst && irq) irq_cnt <= irq_cnt + 1;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_rng(input string req, input int act, input int lo, input int hi);
      n_chk++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic tk(input int n);
      repeat (n * PRE) @(negedge clk);
   endtask

   task automatic send_bit(input logic v, input int per);
      int lo = v ? LO1 : LO0;
      drv = 1'b0;
      tk(lo);
      drv = 1'b1;
      tk(per - lo);
   endtask

   // data MSB first, then EOM, then ACK; returns right after the ACK rises
   task automatic send_byte(input logic [7:0] d, input logic e, input int lidx, input int lper);
      for (int k = 0; k < 10; k++) begin
         logic v = (k < 8) ? d[7-k] : ((k == 8) ? e : 1'b1);
         int lo = v ? LO1 : LO0;
         int per = (k == lidx) ? lper : NOM;
         drv = 1'b0;
         tk(lo);
         drv = 1'b1;
         if (k < 9) tk(per - lo);
      end
   endtask

   task automatic clr_all();
      @(negedge clk);
      flag_clr = 5'h1F;
      @(negedge clk);
      flag_clr = 5'd0;
      chk("R11 clear all", flags, 0);
      irq_base = irq_cnt;
   endtask

   // drive the falling edge that triggers a short cycle and measure the pull
   task automatic short_tail(output int width);
      width = 0;
      drv = 1'b0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (i == 5) drv = 1'b1;
         if (cec_pull) width++;
      end
   endtask

   task automatic t_reset();
      chk("R1 flags", flags, 0);
      chk("R1 rx_data", rx_data, 0);
      chk("R1 irq", irq, 0);
      chk("R1 pull", cec_pull, 0);
   endtask

   task automatic t_single_byte();
      clr_all();
      send_byte(8'hA5, 1'b1, -1, 0);
      @(negedge clk);
      @(negedge clk);
      chk("R2 not before 3 cycles", flags, 0);
      @(negedge clk);
      chk("R2 byte flags", flags, 3);
      chk("R2 data A5", rx_data, 8'hA5);
      tk(40);
      chk("R2 one irq", irq_cnt - irq_base, 1);
   endtask

   task automatic t_two_bytes();
      clr_all();
      send_byte(8'h3C, 1'b0, -1, 0);
      repeat (4) @(negedge clk);
      chk("R3 no EOM flag", flags, 1);
      chk("R3 first data", rx_data, 8'h3C);
      flag_clr = 5'h01;
      @(negedge clk);
      flag_clr = 5'd0;
      chk("R11 clear byte bit", flags, 0);
      tk(NOM - LO1 - 2);
      send_byte(8'h81, 1'b1, -1, 0);
      repeat (4) @(negedge clk);
      chk("R3 second flags", flags, 3);
      chk("R3 second data", rx_data, 8'h81);
      tk(100);
      chk("R3 irq per byte", irq_cnt - irq_base, 2);
   endtask

   task automatic t_short_cycle();
      int w;
      clr_all();
      send_bit(1'b1, NOM);
      send_bit(1'b0, NOM);
      send_bit(1'b1, 30);
      short_tail(w);
      chk("R4 short flag", flags, 8);
      chk("R4 irq", irq_cnt - irq_base, 1);
      chk("R4 data kept", rx_data, 8'h81);
      chk_rng("R4 pull width", w, (ERR - 1) * PRE + 1, ERR * PRE);
   endtask

   task automatic t_long_plain();
      clr_all();
      defer_en = 1'b0;
      send_bit(1'b1, NOM);
      send_bit(1'b1, 65);
      drv = 1'b0;
      tk(LO1);
      drv = 1'b1;
      tk(100);
      chk("R5 long flag", flags, 4);
      chk("R5 irq", irq_cnt - irq_base, 1);
      chk("R5 data kept", rx_data, 8'h81);
      chk("R5 no pull", cec_pull, 0);
   endtask

   task automatic t_long_deferred();
      clr_all();
      defer_en = 1'b1;
      send_byte(8'h5A, 1'b1, 4, 65);
      repeat (4) @(negedge clk);
      chk("R6 flags together", flags, 7);
      chk("R6 data", rx_data, 8'h5A);
      tk(100);
      chk("R6 single irq", irq_cnt - irq_base, 1);
      flag_clr = 5'h04;
      @(negedge clk);
      flag_clr = 5'd0;
      chk("R11 clear one bit", flags, 3);
   endtask

   task automatic t_long_then_short();
      int w;
      clr_all();
      defer_en = 1'b1;
      send_bit(1'b1, NOM);
      send_bit(1'b0, 65);
      send_bit(1'b1, NOM);
      send_bit(1'b1, 30);
      short_tail(w);
      chk("R7 both flags", flags, 12);
      chk("R7 one irq", irq_cnt - irq_base, 1);
      chk("R7 data kept", rx_data, 8'h5A);
   endtask

   task automatic t_timeout();
      clr_all();
      defer_en = 1'b1;
      send_bit(1'b1, NOM);
      send_bit(1'b1, 65);
      send_bit(1'b0, NOM);
      tk(120);
      chk("R8 timeout with held", flags, 20);
      chk("R8 irq", irq_cnt - irq_base, 1);
      clr_all();
      defer_en = 1'b0;
      send_bit(1'b0, NOM);
      send_bit(1'b1, NOM);
      tk(120);
      chk("R8 timeout plain", flags, 16);
      defer_en = 1'b0;
   endtask

   task automatic t_disable();
      clr_all();
      for (int k = 0; k < 5; k++) send_bit(1'b0, NOM);
      rx_en = 1'b0;
      tk(120);
      chk("R9 no flag after abort", flags, 0);
      chk("R9 no irq after abort", irq_cnt - irq_base, 0);
      send_byte(8'hFF, 1'b1, -1, 0);
      tk(60);
      chk("R12 disabled flags", flags, 0);
      chk("R12 disabled data", rx_data, 8'h5A);
      chk("R12 disabled irq", irq_cnt - irq_base, 0);
      rx_en = 1'b1;
      tk(10);
      send_byte(8'hC3, 1'b1, -1, 0);
      repeat (4) @(negedge clk);
      chk("R9 fresh frame data", rx_data, 8'hC3);
      chk("R9 fresh frame flags", flags, 3);
      tk(40);
   endtask

   task automatic t_disable_pull();
      clr_all();
      send_bit(1'b1, NOM);
      send_bit(1'b1, 30);
      drv = 1'b0;
      repeat (6) @(negedge clk);
      drv = 1'b1;
      tk(20);
      chk("R10 pull active", cec_pull, 1);
      rx_en = 1'b0;
      @(negedge clk);
      chk("R10 pull released", cec_pull, 0);
      chk("R10 flag kept", flags, 8);
      rx_en = 1'b1;
      tk(40);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      rx_en = 1'b1;
      tk(5);
      t_single_byte();
      t_two_bytes();
      t_short_cycle();
      t_long_plain();
      t_long_deferred();
      t_long_then_short();
      t_timeout();
      t_disable();
      t_disable_pull();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule